// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block produces one pulse-width-modulated output from an 8-bit cycle counter and a 10-bit duty value. Each counter step (an "instruction cycle") is four clocks long. A 2-bit phase counter walks through those four clocks, so the two finest duty bits place the falling edge on any quarter of a step. The PWM period is set by an 8-bit period register. When the counter equals that register at the end of a step, the counter restarts from zero and the match pulse is raised for one clock.

The duty value is written as two halves: a coarse byte and a fine field. Both land in a shadow buffer and move to the active compare latch only at a period match. So a new duty never changes a cycle already in progress. The period register has no shadow and acts from the next clock. Software that lowers the period must keep it above the running count. If it does not, the counter misses the match, runs through the top of its range, wraps, and matches later, which gives one stretched cycle. Clearing the enable parks the counter, clears the phase and forces the output low.

Top module: `pwm10_gen`

## Requirements
- R1: Each counter step lasts four clocks. With period value P, one PWM cycle lasts 4*(P+1) clocks, measured from one match pulse to the next.
- R2: When the counter equals the period value in the last clock of a step, `match_pulse` is high for exactly that clock. The counter then restarts at 0 with phase 0.
- R3: The duty value D is 10 bits. The coarse part is `dhi_wdata` (D[9:2]). The fine part is bits [7:6] of `dlo_wdata` (D[1:0]). Bits [5:0] of `dlo_wdata` have no effect on the output.
- R4: When the coarse duty is below P, the output is high for exactly D clocks at the start of each cycle, then low for the rest of the cycle. A duty of 0 gives an output that is low for the whole cycle.
- R5: When the active coarse duty is greater than or equal to the period value, the output is high for the whole cycle. This holds even for P = 0 with D = 0.
- R6: Duty writes go to a shadow buffer. They change the active duty only at the next match pulse after the write clock. Each half is buffered on its own, so a match between a coarse write and a fine write latches the new coarse part with the old fine part.
- R7: A period write takes effect at the next clock edge, and it also changes the length of the cycle already in progress.
- R8: If the period is written below the current count, the counter keeps counting to 255, wraps to 0, and matches only when it reaches the new value. The output repeats its high phase after the wrap.
- R9: While `en` is low, `pwm_out` and `match_pulse` stay low and the counter and phase are held at 0. After `en` rises, the first match pulse comes 4*(P+1)-1 clocks after the first enabled clock edge.
- R10: After reset, the period register holds 255, the duty buffer and the active duty are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low parks the timebase and forces the output low |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 8 | New period value |
| dhi_we | input | 1 | Coarse duty write strobe |
| dhi_wdata | input | 8 | Coarse duty value, D[9:2] |
| dlo_we | input | 1 | Fine duty write strobe |
| dlo_wdata | input | 8 | Fine duty register; bits [7:6] carry D[1:0] |
| pwm_out | output | 1 | PWM output |
| match_pulse | output | 1 | One-clock pulse on period match |

## Verification
The assertions run on every cycle. They check that the phase steps by one while enabled and that the counter restarts after a match. They check that the counter otherwise steps by one per step, including the run past the period value, and that it is parked while disabled. They also check that period writes land on the next edge, that the fine field comes from bits 7:6, and that the active duty changes only at a match. Only the bench scenarios can show the waveform itself. These are the high time and the cycle length swept over several periods and all duty values, the 100% rule, the half-written duty mix, the stretched cycle after a too-low period write, and the restart delay after enable.

// File: rtl/pwm10_pkg.sv
// Package: default geometry shared by the PWM generator modules.
// Assumes: the counter width is at least the fine-field width.
package pwm10_pkg;
    localparam int TMR_W_DEF   = 8;
    localparam int FRAC_W_DEF  = 2;
    localparam int PER_RST_DEF = (1 << TMR_W_DEF) - 1;
endpackage

// File: rtl/pwm10_phase.sv
// Module: sub-step phase counter. It walks the clocks inside one counter step
// and flags the last of them. Assumes: a step is 2**FRAC_W clocks long.
module pwm10_phase #(
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [FRAC_W-1:0] phase_o,
    output logic              tick_o
);
    localparam logic [FRAC_W-1:0] LAST = '1;

    logic [FRAC_W-1:0] phase_q;

    // Advance the phase while enabled; park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase_q <= '0;
        else               phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
    assign tick_o  = en && (phase_q == LAST);

    // R1: phase steps by one on every enabled clock.
    a_r1_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase_q == FRAC_W'($past(phase_q) + 1'b1));
endmodule

// File: rtl/pwm10_timebase.sv
// Module: cycle counter and unbuffered period register. It produces the
// period-match event. Assumes: tick_o from the phase counter is gated by en.
module pwm10_timebase #(
    parameter int TMR_W   = pwm10_pkg::TMR_W_DEF,
    parameter int PER_RST = pwm10_pkg::PER_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             per_we,
    input  logic [TMR_W-1:0] per_wdata,
    output logic [TMR_W-1:0] timer_o,
    output logic [TMR_W-1:0] period_o,
    output logic             match_o
);
    localparam logic [TMR_W-1:0] PER_INIT = TMR_W'(PER_RST);

    logic [TMR_W-1:0] timer_q;
    logic [TMR_W-1:0] period_q;
    logic             hit;

    assign hit = tick && (timer_q == period_q);

    // Period register: written straight through, no shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)      period_q <= PER_INIT;
        else if (per_we) period_q <= per_wdata;
    end

    // Cycle counter: restart on match, step on tick, wrap freely otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) timer_q <= '0;
        else if (hit)      timer_q <= '0;
        else if (tick)     timer_q <= timer_q + 1'b1;
    end

    assign timer_o  = timer_q;
    assign period_o = period_q;
    assign match_o  = hit;

    // R9: counter parked while disabled.
    a_r9_timer_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> timer_q == '0);
    // R2: counter restarts after a match.
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> timer_q == '0);
    // R8: without a match the counter steps by one, wrapping past the top.
    a_r8_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !match_o) |=> timer_q == TMR_W'($past(timer_q) + 1'b1));
    // R7: a period write is visible on the next edge.
    a_r7_period_now: assert property (@(posedge clk) disable iff (!rst_n)
        per_we |=> period_q == $past(per_wdata));
endmodule

// File: rtl/pwm10_duty.sv
// Module: duty shadow buffer, active compare latch and output compare.
// Assumes: latch pulses only at a period match; the position is {timer,phase}.
module pwm10_duty #(
    parameter int TMR_W  = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W = pwm10_pkg::FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hi_we,
    input  logic [TMR_W-1:0]  hi_wdata,
    input  logic              lo_we,
    input  logic [TMR_W-1:0]  lo_wdata,
    input  logic              latch,
    input  logic [TMR_W-1:0]  timer,
    input  logic [FRAC_W-1:0] phase,
    input  logic [TMR_W-1:0]  period,
    output logic              pwm_o
);
    localparam int POS_W = TMR_W + FRAC_W;

    logic [TMR_W-1:0]  buf_hi, act_hi;
    logic [FRAC_W-1:0] buf_lo, act_lo;
    logic [FRAC_W-1:0] lo_field;
    logic [POS_W-1:0]  pos, act;
    logic              full;

    assign lo_field = lo_wdata[TMR_W-1 -: FRAC_W];

    // Shadow buffer: each half captured on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_hi <= '0;
            buf_lo <= '0;
        end else begin
            if (hi_we) buf_hi <= hi_wdata;
            if (lo_we) buf_lo <= lo_field;
        end
    end

    // Active latch: copied from the shadow only at a period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi <= '0;
            act_lo <= '0;
        end else if (latch) begin
            act_hi <= buf_hi;
            act_lo <= buf_lo;
        end
    end

    assign pos   = {timer, phase};
    assign act   = {act_hi, act_lo};
    assign full  = (act_hi >= period);
    assign pwm_o = en && (full || (pos < act));

    // R6: active duty holds between matches.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(act_hi) && $stable(act_lo)));
    // R6: a match copies the shadow coarse byte.
    a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> act_hi == $past(buf_hi));
    // R3: the fine field is taken from the top bits of the written byte.
    a_r3_lo_field: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> buf_lo == $past(lo_wdata[TMR_W-1 -: FRAC_W]));
endmodule

// File: rtl/pwm10_gen.sv
// Module: top of the double-buffered fine-resolution PWM generator.
// Assumes: register writes are single-clock strobes, synchronous to clk.
module pwm10_gen #(
    parameter int TMR_W   = pwm10_pkg::TMR_W_DEF,
    parameter int FRAC_W  = pwm10_pkg::FRAC_W_DEF,
    parameter int PER_RST = pwm10_pkg::PER_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             per_we,
    input  logic [TMR_W-1:0] per_wdata,
    input  logic             dhi_we,
    input  logic [TMR_W-1:0] dhi_wdata,
    input  logic             dlo_we,
    input  logic [TMR_W-1:0] dlo_wdata,
    output logic             pwm_out,
    output logic             match_pulse
);
    logic [FRAC_W-1:0] phase;
    logic              tick;
    logic [TMR_W-1:0]  timer;
    logic [TMR_W-1:0]  period;
    logic              match;

    pwm10_phase #(.FRAC_W(FRAC_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en),
        .phase_o(phase), .tick_o(tick)
    );

    pwm10_timebase #(.TMR_W(TMR_W), .PER_RST(PER_RST)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .per_we(per_we), .per_wdata(per_wdata),
        .timer_o(timer), .period_o(period), .match_o(match)
    );

    pwm10_duty #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .en(en),
        .hi_we(dhi_we), .hi_wdata(dhi_wdata),
        .lo_we(dlo_we), .lo_wdata(dlo_wdata),
        .latch(match), .timer(timer), .phase(phase), .period(period),
        .pwm_o(pwm_out)
    );

    assign match_pulse = match;
endmodule

// File: tb/pwm10_gen_tb.sv
module pwm10_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       per_we = 1'b0, dhi_we = 1'b0, dlo_we = 1'b0;
    logic [7:0] per_wdata = '0, dhi_wdata = '0, dlo_wdata = '0;
    logic       pwm_out, match_pulse;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pwm10_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .per_we(per_we), .per_wdata(per_wdata),
        .dhi_we(dhi_we), .dhi_wdata(dhi_wdata),
        .dlo_we(dlo_we), .dlo_wdata(dlo_wdata),
        .pwm_out(pwm_out), .match_pulse(match_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_per(input logic [7:0] v);
        @(negedge clk); per_we = 1'b1; per_wdata = v;
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [7:0] v);
        @(negedge clk); dhi_we = 1'b1; dhi_wdata = v;
        @(negedge clk); dhi_we = 1'b0;
    endtask

    task automatic wr_lo(input logic [7:0] v);
        @(negedge clk); dlo_we = 1'b1; dlo_wdata = v;
        @(negedge clk); dlo_we = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!match_pulse);
    endtask

    // Measure one cycle right after a pulse; optionally inject a write
    // (kind 1: period, 2: coarse duty) at sample number 'at'.
    task automatic meas(input int at, input int kind, input logic [7:0] v,
                        output int n, output int hi);
        n = 0; hi = 0;
        do begin
            @(negedge clk);
            n++;
            if (pwm_out) hi++;
            if (n == at) begin
                if (kind == 1) begin per_we = 1'b1; per_wdata = v; end
                if (kind == 2) begin dhi_we = 1'b1; dhi_wdata = v; end
            end else begin
                per_we = 1'b0; dhi_we = 1'b0;
            end
        end while (!match_pulse && n < 5000);
        per_we = 1'b0; dhi_we = 1'b0;
    endtask

    task automatic set_duty(input int d);
        wr_hi(8'(d >> 2));
        wr_lo(8'((d & 3) << 6));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n, hi, cnt, plist[4];
        plist = '{0, 1, 3, 5};
        repeat (3) @(negedge clk);
        check("R10 reset pwm_out", int'(pwm_out), 0);
        check("R10 reset match_pulse", int'(match_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        // R10: reset period 255 with zero duty -> cycle 1024, output low
        wait_pulse();
        meas(0, 0, 8'h0, n, hi);
        check("R10 reset period length", n, 1024);
        check("R10 reset duty zero", hi, 0);

        // R1 R4 R5: sweep periods and every duty value
        foreach (plist[i]) begin
            int p = plist[i];
            wr_per(8'(p));
            wait_pulse();
            for (int d = 0; d < 4 * p + 8; d++) begin
                int exp_hi;
                set_duty(d);
                wait_pulse();
                meas(0, 0, 8'h0, n, hi);
                exp_hi = ((d >> 2) >= p) ? 4 * (p + 1) : d;
                check("R1 cycle length", n, 4 * (p + 1));
                check(((d >> 2) >= p) ? "R5 full duty" : "R4 duty high time",
                      hi, exp_hi);
            end
        end

        // R6: half writes, R3: fine field position
        wr_per(8'd10);
        set_duty(8);
        wait_pulse();
        meas(0, 0, 8'h0, n, hi);
        check("R6 base duty", hi, 8);
        wr_hi(8'd5);
        wait_pulse();
        meas(0, 0, 8'h0, n, hi);
        check("R6 coarse only with old fine", hi, 20);
        wr_lo(8'hC0);
        wait_pulse();
        meas(0, 0, 8'h0, n, hi);
        check("R3 fine bits 7:6", hi, 23);
        wr_lo(8'h3F);
        wait_pulse();
        meas(0, 0, 8'h0, n, hi);
        check("R3 low bits 5:0 ignored", hi, 20);
        // R6: write during a cycle does not alter that cycle
        wait_pulse();
        meas(2, 2, 8'd1, n, hi);
        check("R6 current cycle keeps old duty", hi, 20);
        meas(0, 0, 8'h0, n, hi);
        check("R6 new duty after match", hi, 4);

        // R8: period lowered below the count
        wr_per(8'd20);
        set_duty(8);
        wait_pulse();
        wait_pulse();
        meas(61, 1, 8'd5, n, hi);
        check("R8 stretched length", n, 1048);
        check("R8 high repeats after wrap", hi, 16);
        meas(0, 0, 8'h0, n, hi);
        check("R7 new short period length", n, 24);
        check("R7 duty in short period", hi, 8);
        // R7: period raised mid-cycle takes effect at once
        meas(2, 1, 8'd12, n, hi);
        check("R7 raised period same cycle", n, 52);

        // R9: disable
        wr_hi(8'd200);
        @(negedge clk);
        en = 1'b0;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pwm_out || match_pulse) cnt++;
        end
        check("R9 outputs low while disabled", cnt, 0);
        en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!match_pulse && n < 5000);
        check("R9 restart delay", n, 51);
        meas(0, 0, 8'h0, n, hi);
        check("R5 coarse above period full", hi, 52);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule